// File: doc/BRIEF.md
# Ring-Capable Core Boundary Cell Chain

This block is a short chain of core boundary cells. It has input-pin cells first and output-pin cells after them. With the ring mode line low, every cell acts as an ordinary wrapper cell. It buffers the pin and the core in the functional direction. One scan stage per cell can either shift along the chain or capture the value at its boundary.

With the ring mode line high, the cells switch to purely combinational routes. A ring of interconnect wires and scan segments can then be closed through them and left to oscillate. Each input-pin cell has a scan-loaded route bit. When the bit is set, the cell forwards its pin to its scan output. When the bit is clear, the cell passes its scan input straight through.

Each output-pin cell forwards its scan input to the next cell. It also drives its pin from the scan input, either inverted or not, under a scan-loaded polarity bit. A test controller uses these bits to make the number of inversions in each ring odd.

The route and polarity bits are first shifted into the scan stages. An update strobe then copies them into a per-cell control register. Later shifting does not disturb the ring configuration that is in use. While the ring mode line is high, all scan and control state is frozen.

Top module: `ring_wrap_chain`

## Requirements
- R1: A synchronous active-low reset clears every scan stage and every control bit. After reset, shifting out gives all zeros. In ring mode, after reset, the chain output follows the chain input, and each output pin equals the chain input without inversion.
- R2: With the ring mode line low, `core_o[k]` equals `pin_i[k]` and `pin_o[j]` equals `core_i[j]` at all times. This holds whatever the shift, capture and update strobes are doing.
- R3: With the ring mode line low and `shift_en` high, each scan stage loads its predecessor on the clock edge. Stage 0 loads `chain_si`, and `chain_so` shows the last stage. Input cells take scan indices 0..N_IN-1 and output cells take N_IN..N_IN+N_OUT-1. After N_IN+N_OUT shifts, the bit driven first sits in the last stage.
- R4: With the ring mode line low, `capture_en` high and `shift_en` low, input cell k's stage loads `pin_i[k]` and output cell j's stage loads `core_i[j]`. Shift has priority over capture.
- R5: With the ring mode line low, `update_en` copies each scan stage into its cell's control bit. Control bits change at no other time, so shifting without an update leaves the ring configuration unchanged.
- R6: In ring mode, input cell k drives its scan output from `pin_i[k]`, without inversion, when its control bit is 1. When the control bit is 0, it drives its scan output from its scan input.
- R7: In ring mode, output cell j drives its scan output from its scan input. It drives `pin_o[j]` with its scan input XOR its control bit, where 1 means invert.
- R8: While the ring mode line is high, the shift, capture and update strobes are ignored. No scan stage and no control bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock for scan stages and control bits |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_test | input | 1 | Ring mode line shared by all cells |
| shift_en | input | 1 | Shift the scan stages along the chain |
| capture_en | input | 1 | Capture boundary values into the scan stages |
| update_en | input | 1 | Copy the scan stages into the control bits |
| chain_si | input | 1 | Serial input of the cell chain |
| chain_so | output | 1 | Serial output of the cell chain |
| pin_i | input | N_IN | Pin values arriving at the input cells |
| core_o | output | N_IN | Values passed from the input cells to the core |
| core_i | input | N_OUT | Core values offered to the output cells |
| pin_o | output | N_OUT | Values driven onto the output pins |

## Verification
The assertions take for granted that at most one of the shift and capture strobes is high in any cycle. They also take for granted that an update is never requested in the same cycle as a shift. The bench keeps to this by raising each strobe inside its own task. The one exception is a deliberate freeze test, in which all three strobes are raised while the ring mode line is high, where the block must ignore them. The ring mode line is changed only while the strobes are low. The bench does not close a real ring, so no combinational loop ever forms.

// File: rtl/ring_wrap_pkg.sv
// Shared definitions for the ring-capable boundary cells.
// Assumes the ring mode line outranks every scan strobe.
package ring_wrap_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } stage_op_e;

    // Choose what a scan stage does this cycle; ring mode freezes it.
    function automatic stage_op_e pick_op(input logic ring, input logic shift,
                                          input logic capture);
        if (ring)
            return OP_HOLD;
        else if (shift)
            return OP_SHIFT;
        else if (capture)
            return OP_CAPTURE;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ring_in_cell.sv
// Input-pin boundary cell. It holds one scan stage and one route control bit.
// Normal mode: the pin is buffered to the core, and scan_o shows the stage.
// Ring mode: scan_o is driven combinationally from the pin (route = 1) or from
// scan_i (route = 0). The path has no inversion.
// Assumes: shift_en and capture_en are never high together.
module ring_in_cell
    import ring_wrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_test,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    input  logic pin_i,
    output logic core_o,
    input  logic scan_i,
    output logic scan_o
);
    stage_op_e op;
    logic      stage_q;
    logic      route_q;
    logic      ring_src;

    assign op = pick_op(osc_test, shift_en, capture_en);

    // Scan stage: shift, capture or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= 1'b0;
        else begin
            case (op)
                OP_SHIFT:   stage_q <= scan_i;
                OP_CAPTURE: stage_q <= pin_i;
                default:    stage_q <= stage_q;
            endcase
        end
    end

    // Control register: loaded from the stage only on an update outside ring mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= 1'b0;
        else if (!osc_test && update_en)
            route_q <= stage_q;
    end

    // Functional buffer, path-select mux, then the mode mux.
    assign core_o   = pin_i;
    assign ring_src = route_q ? pin_i : scan_i;
    assign scan_o   = osc_test ? ring_src : stage_q;

    // R3: a shift loads the predecessor value.
    a_r3_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !osc_test) |=> (stage_q == $past(scan_i)));

    // R4: a capture loads the pin.
    a_r4_capture_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !shift_en && !osc_test) |=> (stage_q == $past(pin_i)));

    // R5: the control bit moves only on an update.
    a_r5_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(route_q));

    // R8: ring mode freezes all state.
    a_r8_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        osc_test |=> ($stable(stage_q) && $stable(route_q)));

endmodule

// File: rtl/ring_out_cell.sv
// Output-pin boundary cell. It holds one scan stage and one polarity control bit.
// Normal mode: the core value is buffered to the pin, and scan_o shows the stage.
// Ring mode: scan_i feeds scan_o directly and also drives the pin. The pin
// path is inverted when the polarity bit is 1.
// Assumes: shift_en and capture_en are never high together.
module ring_out_cell
    import ring_wrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_test,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    input  logic core_i,
    output logic pin_o,
    input  logic scan_i,
    output logic scan_o
);
    stage_op_e op;
    logic      stage_q;
    logic      invert_q;
    logic      ring_pin;

    assign op = pick_op(osc_test, shift_en, capture_en);

    // Scan stage: shift, capture the core value, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= 1'b0;
        else begin
            case (op)
                OP_SHIFT:   stage_q <= scan_i;
                OP_CAPTURE: stage_q <= core_i;
                default:    stage_q <= stage_q;
            endcase
        end
    end

    // Control register: polarity bit loaded on an update outside ring mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            invert_q <= 1'b0;
        else if (!osc_test && update_en)
            invert_q <= stage_q;
    end

    // Selectable buffer (inverting or not), pin mux, then the scan mux.
    assign ring_pin = scan_i ^ invert_q;
    assign pin_o    = osc_test ? ring_pin : core_i;
    assign scan_o   = osc_test ? scan_i : stage_q;

    // R4: a capture loads the core value.
    a_r4_capture_core: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !shift_en && !osc_test) |=> (stage_q == $past(core_i)));

    // R5: an update copies the stage into the polarity bit.
    a_r5_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !osc_test) |=> (invert_q == $past(stage_q)));

    // R8: ring mode freezes all state.
    a_r8_out_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        osc_test |=> ($stable(stage_q) && $stable(invert_q)));

endmodule

// File: rtl/ring_wrap_chain.sv
// A chain of N_IN input cells followed by N_OUT output cells, all sharing one
// ring mode line and the scan strobes.
// Scan order: chain_si -> input cells 0..N_IN-1 -> output cells 0..N_OUT-1 -> chain_so.
// Assumes: at most one of shift_en and capture_en is high, and update_en is
// not raised together with shift_en.
module ring_wrap_chain #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_test,
    input  logic             shift_en,
    input  logic             capture_en,
    input  logic             update_en,
    input  logic             chain_si,
    output logic             chain_so,
    input  logic [N_IN-1:0]  pin_i,
    output logic [N_IN-1:0]  core_o,
    input  logic [N_OUT-1:0] core_i,
    output logic [N_OUT-1:0] pin_o
);
    localparam int N_CELLS = N_IN + N_OUT;

    logic [N_CELLS:0] link;

    assign link[0]  = chain_si;
    assign chain_so = link[N_CELLS];

    // Input-pin cells occupy the head of the chain.
    for (genvar k = 0; k < N_IN; k++) begin : g_in
        ring_in_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .osc_test   (osc_test),
            .shift_en   (shift_en),
            .capture_en (capture_en),
            .update_en  (update_en),
            .pin_i      (pin_i[k]),
            .core_o     (core_o[k]),
            .scan_i     (link[k]),
            .scan_o     (link[k+1])
        );
    end

    // Output-pin cells occupy the tail of the chain.
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        ring_out_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .osc_test   (osc_test),
            .shift_en   (shift_en),
            .capture_en (capture_en),
            .update_en  (update_en),
            .core_i     (core_i[j]),
            .pin_o      (pin_o[j]),
            .scan_i     (link[N_IN+j]),
            .scan_o     (link[N_IN+j+1])
        );
    end

    // R2: outside ring mode the output pins follow the core.
    a_r2_func_out: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_test |-> (pin_o == core_i));

    // R3: a shift moves the next-to-last stage to the chain output.
    a_r3_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !osc_test && !$past(osc_test) && !osc_test) |=>
            (osc_test || chain_so == $past(link[N_CELLS-1])));

    // R4: the strobe inputs keep to their exclusion rule.
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && capture_en) && !(shift_en && update_en));

endmodule

// File: tb/sim_ring_wrap_chain.sv
module sim_ring_wrap_chain;
    localparam int NI = 3;
    localparam int NO = 3;
    localparam int NC = NI + NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_test = 1'b0;
    logic          shift_en = 1'b0;
    logic          capture_en = 1'b0;
    logic          update_en = 1'b0;
    logic          chain_si = 1'b0;
    logic          chain_so;
    logic [NI-1:0] pin_i = '0;
    logic [NI-1:0] core_o;
    logic [NO-1:0] core_i = '0;
    logic [NO-1:0] pin_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ring_wrap_chain #(.N_IN(NI), .N_OUT(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_test(osc_test), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .chain_si(chain_si),
        .chain_so(chain_so), .pin_i(pin_i), .core_o(core_o), .core_i(core_i),
        .pin_o(pin_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Expected ring behaviour: {chain_so, pin_o}, computed from R6 and R7.
    function automatic logic [NO:0] ring_expect(input logic [NC-1:0] cfg,
                                                input logic [NI-1:0] pins,
                                                input logic si);
        logic s;
        logic [NO-1:0] po;
        s = si;
        for (int k = 0; k < NI; k++)
            if (cfg[k]) s = pins[k];
        for (int j = 0; j < NO; j++)
            po[j] = s ^ cfg[NI+j];
        return {s, po};
    endfunction

    task automatic shift_in(input logic [NC-1:0] v);
        for (int i = NC - 1; i >= 0; i--) begin
            chain_si = v[i];
            shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic shift_out_check(input string req, input logic [NC-1:0] exp);
        logic [NC-1:0] got;
        for (int i = NC - 1; i >= 0; i--) begin
            got[i] = chain_so;
            chain_si = 1'b0;
            shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0;
        check(req, got, exp);
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    task automatic ring_check(input string req, input logic [NC-1:0] cfg,
                              input logic [NI-1:0] pins, input logic si);
        pin_i = pins;
        chain_si = si;
        #1;
        check(req, {chain_so, pin_o}, ring_expect(cfg, pins, si));
        check("R2 core_o in ring mode", core_o, pins);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NC-1:0] cfg_a;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state seen through the scan chain and in ring mode.
        osc_test = 1'b1;
        ring_check("R1 reset ring config", '0, 3'b101, 1'b1);
        ring_check("R1 reset ring config", '0, 3'b010, 1'b0);
        osc_test = 1'b0;
        tick();
        shift_out_check("R1 reset scan stages", '0);

        // R2: functional buffering with the strobes active.
        for (int v = 0; v < 64; v++) begin
            pin_i = v[2:0];
            core_i = v[5:3];
            shift_en = v[0];
            capture_en = ~v[0] & v[1];
            tick();
            check("R2 core_o", core_o, v[2:0]);
            check("R2 pin_o", pin_o, v[5:3]);
        end
        shift_en = 1'b0;
        capture_en = 1'b0;

        // R3: shift patterns in and back out.
        shift_in(6'b101101);
        shift_out_check("R3 shift order", 6'b101101);
        shift_in(6'b010011);
        shift_out_check("R3 shift order", 6'b010011);

        // R4: capture from the pins and the core.
        for (int v = 0; v < 8; v++) begin
            pin_i = v[2:0];
            core_i = ~v[2:0];
            capture_en = 1'b1;
            tick();
            capture_en = 1'b0;
            shift_out_check("R4 capture", {~v[2:0], v[2:0]});
        end

        // R6, R7: exhaustive over configurations, pins and ring input.
        for (int c = 0; c < 64; c++) begin
            shift_in(c[5:0]);
            do_update();
            osc_test = 1'b1;
            for (int s = 0; s < 16; s++)
                ring_check("R6 R7 ring paths", c[5:0], s[2:0], s[3]);
            osc_test = 1'b0;
            #1;
        end

        // R5: shifting without an update keeps the old configuration.
        cfg_a = 6'b100101;
        shift_in(cfg_a);
        do_update();
        shift_in(6'b011010);
        osc_test = 1'b1;
        for (int s = 0; s < 16; s++)
            ring_check("R5 control holds", cfg_a, s[2:0], s[3]);
        osc_test = 1'b0;
        tick();

        // R8: strobes are ignored during ring mode.
        osc_test = 1'b1;
        tick();
        shift_en = 1'b1;
        chain_si = 1'b1;
        tick();
        shift_en = 1'b0;
        capture_en = 1'b1;
        pin_i = 3'b111;
        tick();
        capture_en = 1'b0;
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
        for (int s = 0; s < 16; s++)
            ring_check("R8 control frozen", cfg_a, s[2:0], s[3]);
        osc_test = 1'b0;
        tick();
        shift_out_check("R8 stages frozen", 6'b011010);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule